// File: doc/BRIEF.md
# Three-Operand Integer ALU

This block is the integer execute unit of a small load/store RISC core. Each cycle it takes two 32-bit register operands, a 5-bit fixed shift count, a 16-bit immediate and a 5-bit operation code. One clock edge later it presents a 32-bit result and a signed-overflow flag. A small front stage inside the block decides how the immediate is extended and which shift count to use. One shared adder serves addition, subtraction and both magnitude comparisons. A logarithmic shifter serves all six shift forms.

The immediate extension depends on the operation. Add and logical immediates are zero-filled. Set-less-than immediates are sign-filled. The load-upper operation places the immediate in the top half of the result and clears the bottom half. Operation codes with no assigned function yield zero. Multiply, divide, register storage and pipeline control belong to the neighbouring blocks.

Top module: `tri_alu`

## Requirements
- R1: ADD (op 0) and ADDU (op 1) return opa+opb modulo 2^32. ADDI (op 16) and ADDIU (op 17) return opa plus the immediate, with the immediate zero-filled to 32 bits.
- R2: SUB (op 2) and SUBU (op 3) return opa-opb modulo 2^32.
- R3: ovf is 1 exactly when ADD, SUB or ADDI overflows as a two's-complement 32-bit operation. ADDU, SUBU and ADDIU, and every other op, leave ovf at 0.
- R4: AND (op 4), OR (op 5), XOR (op 6) and NOR (op 7) apply the bitwise function to opa and opb.
- R5: ANDI (op 18), ORI (op 19) and XORI (op 20) apply the function to opa and the zero-filled immediate.
- R6: SLT (op 8) and SLTI (op 21) return exactly 1 when opa is below the second operand in two's-complement order, and 0 otherwise. The SLTI immediate is sign-filled.
- R7: SLTU (op 9) and SLTIU (op 22) perform the same test on unsigned 32-bit values. The SLTIU immediate is sign-filled first.
- R8: SLL (op 10), SRL (op 11) and SRA (op 12) shift opb by shamt. SRA copies bit 31 into the vacated bits, and the other two shifts fill with zeros.
- R9: SLLV (op 13), SRLV (op 14) and SRAV (op 15) shift opb by opa[4:0]. The upper bits of opa and the shamt input have no effect.
- R10: LUI (op 23) returns the immediate in bits 31:16 and zeros in bits 15:0.
- R11: result and ovf change only on the rising clock edge that follows the inputs. While rst_n is low, both read 0.
- R12: Op codes 24 to 31 give result 0 and ovf 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 5 | Operation code |
| opa | input | 32 | First operand; also the variable shift count |
| opb | input | 32 | Second operand; the value that is shifted |
| shamt | input | 5 | Fixed shift count |
| imm | input | 16 | Immediate constant |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered signed-overflow flag |

## Verification
Arithmetic is driven with operand pairs at the signed limits: 0x7FFFFFFF+1, 0x80000000-1 and a carry-out with no overflow. These pairs separate the overflow rule from carry-out and from the unsigned forms. Comparisons use pairs in which signed and unsigned order disagree, along with equal operands and negative immediates, which expose swapped signedness and a wrong immediate fill. Shifts use a value with bit 31 set, counts of 0, 1 and 31, and a variable count with junk in the upper opa bits; these tell a logical shift from an arithmetic one and the fixed count from the variable one. Logic ops use complementary patterns, so each function yields a distinct word.

// File: rtl/tri_alu_pkg.sv
`timescale 1ns/1ps
package tri_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_SLLV  = 5'd13,
        OP_SRLV  = 5'd14,
        OP_SRAV  = 5'd15,
        OP_ADDI  = 5'd16,
        OP_ADDIU = 5'd17,
        OP_ANDI  = 5'd18,
        OP_ORI   = 5'd19,
        OP_XORI  = 5'd20,
        OP_SLTI  = 5'd21,
        OP_SLTIU = 5'd22,
        OP_LUI   = 5'd23
    } alu_op_e;

    // Which datapath unit feeds the output register
    typedef enum logic [2:0] {
        U_NONE  = 3'd0,
        U_ADD   = 3'd1,
        U_LOGIC = 3'd2,
        U_CMP   = 3'd3,
        U_SHIFT = 3'd4,
        U_LUI   = 3'd5
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_RA = 2'd2
    } shift_fn_e;

    typedef struct packed {
        unit_e     unit;
        logic      use_imm;
        logic      imm_sext;
        logic      subtract;
        logic      ovf_en;
        logic      cmp_signed;
        logic_fn_e lfn;
        shift_fn_e sfn;
        logic      var_shift;
    } ctrl_t;

endpackage

// File: rtl/tri_alu_decode.sv
`timescale 1ns/1ps
module tri_alu_decode
    import tri_alu_pkg::*;
(
    input  logic [4:0] op_i,
    output ctrl_t      ctrl_o
);

    alu_op_e op_e;

    always_comb begin
        op_e   = alu_op_e'(op_i);
        ctrl_o = '0;
        ctrl_o.unit = U_NONE;
        ctrl_o.lfn  = LG_AND;
        ctrl_o.sfn  = SH_LL;
        case (op_e)
            OP_ADD: begin
                ctrl_o.unit   = U_ADD;
                ctrl_o.ovf_en = 1'b1;
            end
            OP_ADDU: ctrl_o.unit = U_ADD;
            OP_SUB: begin
                ctrl_o.unit     = U_ADD;
                ctrl_o.subtract = 1'b1;
                ctrl_o.ovf_en   = 1'b1;
            end
            OP_SUBU: begin
                ctrl_o.unit     = U_ADD;
                ctrl_o.subtract = 1'b1;
            end
            OP_AND: begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_AND; end
            OP_OR:  begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_OR;  end
            OP_XOR: begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_XOR; end
            OP_NOR: begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_NOR; end
            OP_SLT: begin
                ctrl_o.unit       = U_CMP;
                ctrl_o.subtract   = 1'b1;
                ctrl_o.cmp_signed = 1'b1;
            end
            OP_SLTU: begin
                ctrl_o.unit     = U_CMP;
                ctrl_o.subtract = 1'b1;
            end
            OP_SLL:  begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_LL; end
            OP_SRL:  begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_RL; end
            OP_SRA:  begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_RA; end
            OP_SLLV: begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_LL; ctrl_o.var_shift = 1'b1; end
            OP_SRLV: begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_RL; ctrl_o.var_shift = 1'b1; end
            OP_SRAV: begin ctrl_o.unit = U_SHIFT; ctrl_o.sfn = SH_RA; ctrl_o.var_shift = 1'b1; end
            OP_ADDI: begin
                ctrl_o.unit    = U_ADD;
                ctrl_o.use_imm = 1'b1;
                ctrl_o.ovf_en  = 1'b1;
            end
            OP_ADDIU: begin
                ctrl_o.unit    = U_ADD;
                ctrl_o.use_imm = 1'b1;
            end
            OP_ANDI: begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_AND; ctrl_o.use_imm = 1'b1; end
            OP_ORI:  begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_OR;  ctrl_o.use_imm = 1'b1; end
            OP_XORI: begin ctrl_o.unit = U_LOGIC; ctrl_o.lfn = LG_XOR; ctrl_o.use_imm = 1'b1; end
            OP_SLTI: begin
                ctrl_o.unit       = U_CMP;
                ctrl_o.subtract   = 1'b1;
                ctrl_o.cmp_signed = 1'b1;
                ctrl_o.use_imm    = 1'b1;
                ctrl_o.imm_sext   = 1'b1;
            end
            OP_SLTIU: begin
                ctrl_o.unit     = U_CMP;
                ctrl_o.subtract = 1'b1;
                ctrl_o.use_imm  = 1'b1;
                ctrl_o.imm_sext = 1'b1;
            end
            OP_LUI: ctrl_o.unit = U_LUI;
            default: ctrl_o.unit = U_NONE;
        endcase
    end

endmodule

// File: rtl/tri_alu_operand.sv
`timescale 1ns/1ps
module tri_alu_operand
    import tri_alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN)
) (
    input  ctrl_t             ctrl_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [XLEN-1:0]   b_o,
    output logic [SH_W-1:0]   amt_o
);

    localparam int PAD_W = XLEN - IMM_W;

    logic              fill_bit;
    logic [XLEN-1:0]   imm_ext;

    always_comb begin
        fill_bit = ctrl_i.imm_sext & imm_i[IMM_W-1];
        imm_ext  = {{PAD_W{fill_bit}}, imm_i};
        b_o      = ctrl_i.use_imm ? imm_ext : opb_i;
        amt_o    = ctrl_i.var_shift ? opa_i[SH_W-1:0] : shamt_i;
    end

endmodule

// File: rtl/tri_alu_addsub.sv
`timescale 1ns/1ps
module tri_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);

    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_x;
    logic [XLEN:0]   wide;

    always_comb begin
        b_x    = b_i ^ {XLEN{sub_i}};
        wide   = {1'b0, a_i} + {1'b0, b_x} + {{XLEN{1'b0}}, sub_i};
        sum_o  = wide[MSB:0];
        ovf_o  = (a_i[MSB] == b_x[MSB]) && (wide[MSB] != a_i[MSB]);
        // Valid when subtracting: no carry out means a borrow, so a < b unsigned
        lt_u_o = ~wide[XLEN];
        lt_s_o = wide[MSB] ^ ovf_o;
    end

endmodule

// File: rtl/tri_alu_shifter.sv
`timescale 1ns/1ps
module tri_alu_shifter
    import tri_alu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SH_W-1:0] amt_i,
    input  shift_fn_e       fn_i,
    output logic [XLEN-1:0] res_o
);

    logic fill;
    logic go_left;

    assign fill    = (fn_i == SH_RA) & val_i[XLEN-1];
    assign go_left = (fn_i == SH_LL);

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [XLEN-1:0] din;
        logic [XLEN-1:0] dout;
        if (k == 0) begin : g_first
            assign din = val_i;
        end else begin : g_next
            assign din = g_stage[k-1].dout;
        end
        always_comb begin
            if (!amt_i[k]) begin
                dout = din;
            end else if (go_left) begin
                dout = {din[XLEN-1-D:0], {D{1'b0}}};
            end else begin
                dout = {{D{fill}}, din[XLEN-1:D]};
            end
        end
    end

    assign res_o = g_stage[SH_W-1].dout;

endmodule

// File: rtl/tri_alu.sv
`timescale 1ns/1ps
module tri_alu
    import tri_alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [SH_W-1:0]   shamt,
    input  logic [IMM_W-1:0]  imm,
    output logic [XLEN-1:0]   result,
    output logic              ovf
);

    localparam int LOW_W = XLEN - IMM_W;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            ovf;
    } out_t;

    ctrl_t           ctrl;
    logic [XLEN-1:0] b_eff;
    logic [SH_W-1:0] sh_amt;
    logic [XLEN-1:0] sum;
    logic            add_ovf;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] sh_res;

    out_t out_d;
    out_t out_q;

    tri_alu_decode u_dec (
        .op_i   (op),
        .ctrl_o (ctrl)
    );

    tri_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
        .ctrl_i  (ctrl),
        .opa_i   (opa),
        .opb_i   (opb),
        .shamt_i (shamt),
        .imm_i   (imm),
        .b_o     (b_eff),
        .amt_o   (sh_amt)
    );

    tri_alu_addsub #(.XLEN(XLEN)) u_add (
        .a_i    (opa),
        .b_i    (b_eff),
        .sub_i  (ctrl.subtract),
        .sum_o  (sum),
        .ovf_o  (add_ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    tri_alu_shifter #(.XLEN(XLEN)) u_shf (
        .val_i (opb),
        .amt_i (sh_amt),
        .fn_i  (ctrl.sfn),
        .res_o (sh_res)
    );

    always_comb begin
        out_d = '0;
        case (ctrl.unit)
            U_ADD: begin
                out_d.res = sum;
                out_d.ovf = ctrl.ovf_en & add_ovf;
            end
            U_CMP: begin
                out_d.res = {{(XLEN-1){1'b0}}, (ctrl.cmp_signed ? lt_s : lt_u)};
            end
            U_LOGIC: begin
                case (ctrl.lfn)
                    LG_AND:  out_d.res = opa & b_eff;
                    LG_OR:   out_d.res = opa | b_eff;
                    LG_XOR:  out_d.res = opa ^ b_eff;
                    default: out_d.res = ~(opa | b_eff);
                endcase
            end
            U_SHIFT: out_d.res = sh_res;
            U_LUI:   out_d.res = {imm, {LOW_W{1'b0}}};
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result = out_q.res;
    assign ovf    = out_q.ovf;

endmodule

// File: rtl/tri_alu_chk.sv
`timescale 1ns/1ps
module tri_alu_chk #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op,
    input logic [SH_W-1:0]   var_amt,
    input logic [XLEN-1:0]   opb,
    input logic [SH_W-1:0]   shamt,
    input logic [IMM_W-1:0]  imm,
    input logic [XLEN-1:0]   result,
    input logic              ovf
);

    localparam int LOW_W = XLEN - IMM_W;

    // R3
    unsigned_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == 5'd1 || $past(op) == 5'd3 || $past(op) == 5'd17)) |-> !ovf);

    // R3
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ovf) |-> ($past(op) == 5'd0 || $past(op) == 5'd2 || $past(op) == 5'd16));

    // R6
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == 5'd8 || $past(op) == 5'd9 || $past(op) == 5'd21 || $past(op) == 5'd22))
        |-> (result[XLEN-1:1] == '0));

    // R10
    lui_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 5'd23) |-> (result == {$past(imm), {LOW_W{1'b0}}}));

    // R8
    sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 5'd12 && $past(opb[XLEN-1])) |-> result[XLEN-1]);

    // R9
    var_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == 5'd13 || $past(op) == 5'd14 || $past(op) == 5'd15)
         && $past(var_amt) == '0) |-> (result == $past(opb)));

    // R8
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) >= 5'd10 && $past(op) <= 5'd12 && $past(shamt) == '0)
        |-> (result == $past(opb)));

    // R12
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) >= 5'd24) |-> (result == '0 && !ovf));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (result == '0 && !ovf));

endmodule

bind tri_alu tri_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .var_amt (opa[SH_W-1:0]),
    .opb     (opb),
    .shamt   (shamt),
    .imm     (imm),
    .result  (result),
    .ovf     (ovf)
);

// File: tb/sim_tri_alu.sv
`timescale 1ns/1ps
module sim_tri_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        ovf;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tri_alu u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .shamt  (shamt),
        .imm    (imm),
        .result (result),
        .ovf    (ovf)
    );

    function automatic void model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] s, input logic [15:0] im,
                                  output logic [31:0] r, output logic v);
        logic [31:0] zi;
        logic [31:0] si;
        longint      t;
        zi = {16'h0000, im};
        si = {{16{im[15]}}, im};
        r  = '0;
        v  = 1'b0;
        t  = 0;
        case (o)
            5'd0:  begin r = a + b;  t = longint'($signed(a)) + longint'($signed(b));  v = 1'b1; end
            5'd1:  r = a + b;
            5'd2:  begin r = a - b;  t = longint'($signed(a)) - longint'($signed(b));  v = 1'b1; end
            5'd3:  r = a - b;
            5'd4:  r = a & b;
            5'd5:  r = a | b;
            5'd6:  r = a ^ b;
            5'd7:  r = ~(a | b);
            5'd8:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            5'd9:  r = (a < b) ? 32'd1 : 32'd0;
            5'd10: r = b << s;
            5'd11: r = b >> s;
            5'd12: r = $unsigned($signed(b) >>> s);
            5'd13: r = b << a[4:0];
            5'd14: r = b >> a[4:0];
            5'd15: r = $unsigned($signed(b) >>> a[4:0]);
            5'd16: begin r = a + zi; t = longint'($signed(a)) + longint'($signed(zi)); v = 1'b1; end
            5'd17: r = a + zi;
            5'd18: r = a & zi;
            5'd19: r = a | zi;
            5'd20: r = a ^ zi;
            5'd21: r = ($signed(a) < $signed(si)) ? 32'd1 : 32'd0;
            5'd22: r = (a < si) ? 32'd1 : 32'd0;
            5'd23: r = {im, 16'h0000};
            default: r = '0;
        endcase
        if (v) v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got ovf=%0b result=%08h, expected ovf=%0b result=%08h",
                     req, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic run(input string req, input logic [4:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s, input logic [15:0] im);
        logic [31:0] er;
        logic        ev;
        @(negedge clk);
        op = o; opa = a; opb = b; shamt = s; imm = im;
        model(o, a, b, s, im, er, ev);
        @(negedge clk);
        check(req, {ovf, result}, {ev, er});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op = 5'd0; opa = 32'h7FFF_FFFF; opb = 32'h1; imm = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R11 reset clears", {ovf, result}, 33'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        @(negedge clk);
        op = 5'd1; opa = 32'd5; opb = 32'd6;
        @(negedge clk);
        check("R11 after edge", {ovf, result}, {1'b0, 32'd11});
        op = 5'd1; opa = 32'd100; opb = 32'd1;
        #1;
        check("R11 holds until edge", {ovf, result}, {1'b0, 32'd11});
        @(negedge clk);
        check("R11 next value", {ovf, result}, {1'b0, 32'd101});
    endtask

    task automatic t_add();
        run("R1 add", 5'd0, 32'h0000_1234, 32'h0000_4321, 5'd0, 16'h0);
        run("R1 addu carry", 5'd1, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0, 16'h0);
        run("R1 addiu zero-fill", 5'd17, 32'h0000_0001, 32'h0, 5'd0, 16'hFFFF);
        run("R1 addi", 5'd16, 32'h1000_0000, 32'h0, 5'd0, 16'h8000);
    endtask

    task automatic t_sub();
        run("R2 sub", 5'd2, 32'd10, 32'd3, 5'd0, 16'h0);
        run("R2 subu wrap", 5'd3, 32'd3, 32'd10, 5'd0, 16'h0);
    endtask

    task automatic t_ovf();
        run("R3 add pos ovf", 5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 16'h0);
        run("R3 add neg ovf", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 16'h0);
        run("R3 add carry no ovf", 5'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0);
        run("R3 sub ovf", 5'd2, 32'h8000_0000, 32'h1, 5'd0, 16'h0);
        run("R3 addi ovf", 5'd16, 32'h7FFF_FFF0, 32'h0, 5'd0, 16'h0100);
        run("R3 addu no flag", 5'd1, 32'h7FFF_FFFF, 32'h1, 5'd0, 16'h0);
        run("R3 subu no flag", 5'd3, 32'h8000_0000, 32'h1, 5'd0, 16'h0);
        run("R3 addiu no flag", 5'd17, 32'h7FFF_FFFF, 32'h0, 5'd0, 16'h0001);
    endtask

    task automatic t_logic();
        run("R4 and", 5'd4, 32'hF0F0_AAAA, 32'hFF00_5555, 5'd0, 16'h0);
        run("R4 or",  5'd5, 32'hF0F0_AAAA, 32'hFF00_5555, 5'd0, 16'h0);
        run("R4 xor", 5'd6, 32'hF0F0_AAAA, 32'hFF00_5555, 5'd0, 16'h0);
        run("R4 nor", 5'd7, 32'hF0F0_AAAA, 32'hFF00_5555, 5'd0, 16'h0);
    endtask

    task automatic t_logic_imm();
        run("R5 andi", 5'd18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'h8F0F);
        run("R5 ori",  5'd19, 32'h1234_0000, 32'h0, 5'd0, 16'h8001);
        run("R5 xori", 5'd20, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'hF000);
    endtask

    task automatic t_slt();
        run("R6 slt neg<pos", 5'd8, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0);
        run("R6 slt pos>neg", 5'd8, 32'h1, 32'hFFFF_FFFF, 5'd0, 16'h0);
        run("R6 slt equal", 5'd8, 32'h55, 32'h55, 5'd0, 16'h0);
        run("R6 slt extremes", 5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0);
        run("R6 slti neg imm", 5'd21, 32'hFFFF_FFF0, 32'h0, 5'd0, 16'hFFFF);
        run("R6 slti false", 5'd21, 32'h0, 32'h0, 5'd0, 16'hFFFF);
    endtask

    task automatic t_sltu();
        run("R7 sltu big", 5'd9, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0);
        run("R7 sltu small", 5'd9, 32'h1, 32'hFFFF_FFFF, 5'd0, 16'h0);
        run("R7 sltiu sign-fill", 5'd22, 32'h8000_0000, 32'h0, 5'd0, 16'hFFFF);
        run("R7 sltiu equal", 5'd22, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'hFFFF);
    endtask

    task automatic t_shift_fixed();
        run("R8 sll", 5'd10, 32'hFFFF_0000, 32'h8000_0001, 5'd1, 16'h0);
        run("R8 srl", 5'd11, 32'h0, 32'h8000_0001, 5'd31, 16'h0);
        run("R8 sra", 5'd12, 32'h0, 32'h8000_0010, 5'd4, 16'h0);
        run("R8 sra pos", 5'd12, 32'h0, 32'h4000_0000, 5'd30, 16'h0);
        run("R8 zero count", 5'd11, 32'h0, 32'hDEAD_BEEF, 5'd0, 16'h0);
    endtask

    task automatic t_shift_var();
        run("R9 sllv high bits ignored", 5'd13, 32'hFFFF_FFE4, 32'h0000_0003, 5'd7, 16'h0);
        run("R9 srlv", 5'd14, 32'h0000_0108, 32'hF000_0000, 5'd1, 16'h0);
        run("R9 srav", 5'd15, 32'h0000_001F, 32'h8000_0000, 5'd3, 16'h0);
        run("R9 srav zero count", 5'd15, 32'hFFFF_FFE0, 32'h8765_4321, 5'd9, 16'h0);
    endtask

    task automatic t_lui();
        run("R10 lui", 5'd23, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 16'hA5C3);
        run("R10 lui zero", 5'd23, 32'h1234_5678, 32'h0, 5'd0, 16'h0000);
    endtask

    task automatic t_unused();
        for (int k = 24; k < 32; k++) begin
            run("R12 unused op", 5'(k), 32'h7FFF_FFFF, 32'h0000_0001, 5'd4, 16'hFFFF);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_add();
        t_sub();
        t_ovf();
        t_logic();
        t_logic_imm();
        t_slt();
        t_sltu();
        t_shift_fixed();
        t_shift_var();
        t_lui();
        t_unused();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
            $finish;
        end
    end

endmodule